// File: doc/BRIEF.md
# Channel activity counters

This block measures how a radio channel is occupied. It keeps four 32-bit cycle counters. One counts every clock. One counts cycles in which the medium is sensed busy. One counts cycles in which a frame is being received, and one counts cycles in which a frame is being sent. Three status flags, sampled once per clock, drive the three conditional counters. A small register bus gives software access to all of the counters.

Software takes a consistent measurement in a fixed order. It first sets the freeze bit, which stops all four counters on the same edge. It then reads the four counters and writes zero to each of them. Last, it clears the freeze bit so that counting resumes. The block also derives an idle (listening) cycle count: total cycles less receive-frame cycles less transmit-frame cycles, held at zero when the subtraction would go negative. This count is available on a dedicated output and at its own register address.

Top module: `chan_activity_counters`

## Requirements
- R1: After synchronous reset, all four counters are zero, the freeze bit is clear, `reg_rvalid` is low and `idle_cycles` is zero.
- R2: While not frozen, the total counter (address 1) increments on every clock edge.
- R3: While not frozen, the busy (address 2), receive-frame (address 3) and transmit-frame (address 4) counters increment only on edges where `chan_busy`, `rx_active` or `tx_active` respectively is high.
- R4: Writing the control register (address 0) with bit 0 set freezes all four counters together. The edge that performs that write still counts. Writing 0 to address 0 resumes counting from the next edge. A read of address 0 returns the freeze state in bit 0, with the other bits zero.
- R5: A write to a counter address loads the write data into that counter, whether or not the counters are frozen. Writing zero clears the counter.
- R6: When a counter write and an increment fall on the same edge, the written value is stored and the increment is lost.
- R7: Counters wrap modulo 2^32, so all ones plus one gives zero.
- R8: A read strobe at an edge returns, one cycle later, the addressed value as it stood just before that edge, with `reg_rvalid` high for exactly that one cycle.
- R9: `idle_cycles`, and a read of address 5, equal total minus receive-frame minus transmit-frame when that difference is non-negative. Otherwise they are zero, including when the two subtracted counts together exceed 32 bits.
- R10: Writes to address 5 and to unmapped addresses 6 and 7 change no counter and no control state. Reads of addresses 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_busy | input | 1 | Medium sensed busy this cycle |
| rx_active | input | 1 | Frame reception in progress this cycle |
| tx_active | input | 1 | Frame transmission in progress this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| idle_cycles | output | 32 | Saturated idle-cycle count |

## Verification
The properties assume that every input is a known 0 or 1 after reset. They also assume that a counter changes only through its own increment or through a write to its own address, so any counter write is visible on the bus ports in the same cycle. The bench meets these conditions by driving every input only on falling edges. It holds both strobes low during reset and keeps the flags at defined levels at all times. Expected counts come from summing the flag pattern over a known number of unfrozen edges. The sweep covers all eight constant flag combinations and one mixed periodic pattern, with preloaded values that exercise wrap-around and saturation.

// File: rtl/chan_act_pkg.sv
package chan_act_pkg;

    localparam int unsigned NUM_CNT = 4;

    // Register word addresses (counters occupy CNT_BASE .. CNT_BASE+NUM_CNT-1)
    localparam int unsigned ADR_CTRL = 0;
    localparam int unsigned ADR_CNT_BASE = 1;
    localparam int unsigned ADR_IDLE = ADR_CNT_BASE + NUM_CNT;

    // Counter slot order; address = ADR_CNT_BASE + slot
    typedef enum logic [1:0] {
        SLOT_TOTAL = 2'd0,
        SLOT_BUSY  = 2'd1,
        SLOT_RXF   = 2'd2,
        SLOT_TXF   = 2'd3
    } cnt_slot_e;

    typedef struct packed {
        logic txf;
        logic rxf;
        logic busy;
    } chan_flags_t;

    // Per-slot increment qualifier: total counts always
    function automatic logic [NUM_CNT-1:0] slot_qualify(chan_flags_t f);
        logic [NUM_CNT-1:0] m;
        m = '0;
        m[SLOT_TOTAL] = 1'b1;
        m[SLOT_BUSY]  = f.busy;
        m[SLOT_RXF]   = f.rxf;
        m[SLOT_TXF]   = f.txf;
        return m;
    endfunction

endpackage

// File: rtl/chan_act_counter.sv
module chan_act_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         en,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;                // load wins over increment
        end else if (en) begin
            q <= q + W'(1);             // modulo 2^W
        end
    end

endmodule

// File: rtl/chan_act_idle.sv
module chan_act_idle #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] total,
    input  logic [W-1:0] rxf,
    input  logic [W-1:0] txf,
    output logic [W-1:0] idle
);

    localparam int unsigned XW = W + 1;

    logic [XW-1:0] used;
    logic [XW-1:0] tot_x;
    logic [XW-1:0] diff;

    always_comb begin
        used  = {1'b0, rxf} + {1'b0, txf};
        tot_x = {1'b0, total};
        diff  = tot_x - used;
        idle  = (used > tot_x) ? '0 : diff[W-1:0];
    end

endmodule

// File: rtl/chan_act_regif.sv
module chan_act_regif
    import chan_act_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [CNT_W-1:0]               wdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_val,
    input  logic [CNT_W-1:0]               idle_val,
    output logic                           frz,
    output logic [NUM_CNT-1:0]             ld,
    output logic [CNT_W-1:0]               rdata,
    output logic                           rvalid
);

    logic             ctrl_hit;
    logic [CNT_W-1:0] rd_mux;

    assign ctrl_hit = wr_en && (addr == ADDR_W'(ADR_CTRL));

    always_comb begin
        for (int i = 0; i < NUM_CNT; i++) begin
            ld[i] = wr_en && (addr == ADDR_W'(ADR_CNT_BASE + i));
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(ADR_CTRL)) begin
            rd_mux = {{(CNT_W-1){1'b0}}, frz};
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == ADDR_W'(ADR_CNT_BASE + i)) begin
                rd_mux = cnt_val[i];
            end
        end
        if (addr == ADDR_W'(ADR_IDLE)) begin
            rd_mux = idle_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frz    <= 1'b0;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            if (ctrl_hit) begin
                frz <= wdata[0];
            end
            if (rd_en) begin
                rdata <= rd_mux;
            end
            rvalid <= rd_en;
        end
    end

endmodule

// File: rtl/chan_activity_counters.sv
module chan_activity_counters
    import chan_act_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_busy,
    input  logic              rx_active,
    input  logic              tx_active,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              reg_rvalid,
    output logic [CNT_W-1:0]  idle_cycles
);

    chan_flags_t                    flags;
    logic                           frz;
    logic [NUM_CNT-1:0]             ld_vec;
    logic [NUM_CNT-1:0]             cnt_en;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_val;
    logic [CNT_W-1:0]               idle_val;

    assign flags  = '{txf: tx_active, rxf: rx_active, busy: chan_busy};
    assign cnt_en = frz ? '0 : slot_qualify(flags);

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        chan_act_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .ld     (ld_vec[g]),
            .ld_val (reg_wdata),
            .en     (cnt_en[g]),
            .q      (cnt_val[g])
        );
    end

    chan_act_idle #(.W(CNT_W)) u_idle (
        .total (cnt_val[SLOT_TOTAL]),
        .rxf   (cnt_val[SLOT_RXF]),
        .txf   (cnt_val[SLOT_TXF]),
        .idle  (idle_val)
    );

    chan_act_regif #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cnt_val  (cnt_val),
        .idle_val (idle_val),
        .frz      (frz),
        .ld       (ld_vec),
        .rdata    (reg_rdata),
        .rvalid   (reg_rvalid)
    );

    assign idle_cycles = idle_val;

endmodule

// File: rtl/chan_act_checker.sv
module chan_act_checker
    import chan_act_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           chan_busy,
    input  logic                           reg_wr_en,
    input  logic                           reg_rd_en,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [CNT_W-1:0]               reg_wdata,
    input  logic                           reg_rvalid,
    input  logic [CNT_W-1:0]               idle_cycles,
    input  logic                           frz,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_val
);

    logic wr_total, wr_busy, wr_rxf;
    assign wr_total = reg_wr_en && (reg_addr == ADDR_W'(ADR_CNT_BASE + 0));
    assign wr_busy  = reg_wr_en && (reg_addr == ADDR_W'(ADR_CNT_BASE + 1));
    assign wr_rxf   = reg_wr_en && (reg_addr == ADDR_W'(ADR_CNT_BASE + 2));

    assert_total_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!frz && !wr_total) |=> cnt_val[0] == CNT_W'($past(cnt_val[0]) + 1));

    assert_busy_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!chan_busy && !wr_busy) |=> $stable(cnt_val[1]));

    assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (frz && !reg_wr_en) |=> $stable(cnt_val));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        wr_rxf |=> cnt_val[2] == $past(reg_wdata));

    assert_rvalid_rise_R8: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> reg_rvalid);

    assert_rvalid_low_R8: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_en |=> !reg_rvalid);

    assert_idle_bound_R9: assert property (@(posedge clk) disable iff (rst)
        idle_cycles <= cnt_val[0]);

endmodule

bind chan_activity_counters chan_act_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .chan_busy   (chan_busy),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rvalid  (reg_rvalid),
    .idle_cycles (idle_cycles),
    .frz         (frz),
    .cnt_val     (cnt_val)
);

// File: tb/chan_activity_counters_bench.sv
module chan_activity_counters_bench;

    localparam int CW = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          busy = 1'b0, rxa = 1'b0, txa = 1'b0;
    logic          wr = 1'b0, rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          rvalid;
    logic [CW-1:0] idle;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    chan_activity_counters #(.CNT_W(CW), .ADDR_W(AW)) u_chan_activity_counters (
        .clk(clk), .rst(rst), .chan_busy(busy), .rx_active(rxa), .tx_active(txa),
        .reg_wr_en(wr), .reg_rd_en(rd), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .reg_rvalid(rvalid), .idle_cycles(idle)
    );

    task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [CW-1:0] d);
        addr = AW'(a); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [CW-1:0] d);
        addr = AW'(a); rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk("R8 rvalid after read", CW'(rvalid), 1);
        d = rdata;
    endtask

    task automatic set_flags(input logic [2:0] f);
        {txa, rxa, busy} = f;
    endtask

    function automatic logic [2:0] pat(input int mode, input int j);
        if (mode < 8) return 3'(mode);
        return {(j % 5) == 0, (j % 3) == 0, (j % 2) == 1};
    endfunction

    function automatic logic [CW-1:0] sat_idle(input longint t, input longint r, input longint x);
        return (r + x > t) ? '0 : CW'(t - r - x);
    endfunction

    // Freeze, clear, run k+1 unfrozen edges with pattern, freeze, read back
    task automatic measure(input int mode, input int k);
        logic [CW-1:0] v;
        longint e_t, e_b, e_r, e_x;
        wr_reg(0, 1);
        for (int c = 1; c <= 4; c++) wr_reg(c, 0);
        set_flags(pat(mode, 0));
        wr_reg(0, 0);
        for (int j = 0; j < k; j++) begin
            set_flags(pat(mode, j));
            @(negedge clk);
        end
        set_flags(pat(mode, k));
        wr_reg(0, 1);
        set_flags(3'b000);
        e_t = k + 1; e_b = 0; e_r = 0; e_x = 0;
        for (int j = 0; j <= k; j++) begin
            logic [2:0] p;
            p = pat(mode, j);
            e_b += p[0]; e_r += p[1]; e_x += p[2];
        end
        rd_reg(1, v); chk($sformatf("R2 total mode %0d", mode), v, CW'(e_t));
        rd_reg(2, v); chk($sformatf("R3 busy mode %0d", mode), v, CW'(e_b));
        rd_reg(3, v); chk($sformatf("R3 rxf mode %0d", mode), v, CW'(e_r));
        rd_reg(4, v); chk($sformatf("R3 txf mode %0d", mode), v, CW'(e_x));
        rd_reg(5, v); chk($sformatf("R9 idle reg mode %0d", mode), v, sat_idle(e_t, e_r, e_x));
        chk($sformatf("R9 idle port mode %0d", mode), idle, sat_idle(e_t, e_r, e_x));
        rd_reg(0, v); chk("R4 ctrl reads frozen", v, 1);
        repeat (7) @(negedge clk);
        rd_reg(1, v); chk("R4 total held while frozen", v, CW'(e_t));
    endtask

    initial begin
        logic [CW-1:0] v;
        repeat (4) @(negedge clk);
        chk("R1 rvalid in reset", CW'(rvalid), 0);
        chk("R1 idle in reset", idle, 0);
        // release reset and read total at the first live edge
        rst = 1'b0; addr = AW'(1); rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk("R1 total zero after reset", rdata, 0);
        rd_reg(2, v); chk("R1 busy zero after reset", v, 0);
        rd_reg(0, v); chk("R1 not frozen after reset", v, 0);

        // R2 R3 R4 R9: constant flag sweep and mixed pattern
        for (int m = 0; m < 8; m++) measure(m, 3 + 5 * m);
        measure(8, 40);
        measure(8, 1);

        // R8: read while counting returns value before the edge
        for (int c = 1; c <= 4; c++) wr_reg(c, 0);
        wr_reg(0, 0);
        addr = AW'(1); rd = 1'b1;
        @(negedge clk);
        chk("R8 first live read", rdata, 0);
        chk("R8 rvalid", CW'(rvalid), 1);
        @(negedge clk);
        rd = 1'b0;
        chk("R8 back-to-back read", rdata, 1);
        @(negedge clk);
        chk("R8 rvalid drops", CW'(rvalid), 0);
        rd_reg(0, v); chk("R4 ctrl reads unfrozen", v, 0);

        // R6: write collides with increment
        wr_reg(0, 1);
        for (int c = 1; c <= 4; c++) wr_reg(c, 0);
        set_flags(3'b010);
        wr_reg(0, 0);
        wr_reg(3, 100);
        wr_reg(0, 1);
        set_flags(3'b000);
        rd_reg(3, v); chk("R6 write beats increment", v, 101);
        rd_reg(1, v); chk("R2 total over collision", v, 2);

        // R5: load nonzero while frozen, clear with zero
        wr_reg(4, 32'h0000_1234);
        rd_reg(4, v); chk("R5 load while frozen", v, 32'h0000_1234);
        wr_reg(4, 0);
        rd_reg(4, v); chk("R5 clear by zero", v, 0);

        // R7: wrap
        wr_reg(1, '1); wr_reg(2, '1);
        set_flags(3'b001);
        wr_reg(0, 0);
        wr_reg(0, 1);
        set_flags(3'b000);
        rd_reg(1, v); chk("R7 total wraps", v, 0);
        rd_reg(2, v); chk("R7 busy wraps", v, 0);

        // R9: idle arithmetic on loaded values
        wr_reg(1, 1000); wr_reg(3, 300); wr_reg(4, 200);
        rd_reg(5, v); chk("R9 idle difference", v, 500);
        chk("R9 idle port difference", idle, 500);
        wr_reg(1, 100); wr_reg(3, 60); wr_reg(4, 60);
        rd_reg(5, v); chk("R9 idle saturates", v, 0);
        wr_reg(1, '1); wr_reg(3, '1); wr_reg(4, 2);
        rd_reg(5, v); chk("R9 idle saturates on wide sum", v, 0);
        chk("R9 idle port wide sum", idle, 0);

        // R10: ignored writes, unmapped reads
        wr_reg(1, 77); wr_reg(3, 7); wr_reg(4, 0);
        wr_reg(5, 32'hFFFF_FFFF);
        wr_reg(6, 32'h0000_0000);
        wr_reg(7, 32'h0000_0000);
        rd_reg(5, v); chk("R10 idle write ignored", v, 70);
        rd_reg(1, v); chk("R10 total untouched", v, 77);
        rd_reg(0, v); chk("R10 freeze untouched", v, 1);
        rd_reg(6, v); chk("R10 unmapped read 6", v, 0);
        rd_reg(7, v); chk("R10 unmapped read 7", v, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule